// File: doc/BRIEF.md
# Scatter-Gather Page Sequencer

This block walks a main DMA engine through a list of memory pages. Software hands it one page at a time as a start address, a byte count and a page-interrupt flag. It keeps two page slots. The current slot is the page being transferred. The queued slot holds the page that follows. Software can therefore load the following page while the present one is still moving. The page-interrupt flag stays with its page when the page moves from the queued slot into the current slot.

Incoming bytes are consumed one per cycle while a page is active, and the remaining count goes down by one for each. The bytes leave as memory writes. In single-byte mode every byte is written as soon as it arrives. In grouped mode bytes are gathered into wider words before they are written. When a flagged page finishes and the local page-interrupt enable is set, a sticky interrupt is raised. It reaches the interrupt pin only while the global interrupt enable is set. The only way to clear it is to drop the local enable. Status outputs report whether the engine is idle, whether the queued slot is empty, the flags of both slots, and the count of the queued page.

Top module: `sg_page_seq`

## Requirements
- R1: After reset, dma_done=1, nxt_empty=1, nxt_cnt_rd=0, pg_irq=0, irq_out=0 and wr_vld=0.
- R2: A page write (nxt_wr=1, non-zero count) while a page is active and the queued slot is empty fills the queued slot. On the next cycle nxt_empty=0, nxt_cnt_rd shows the written count and nxt_pint shows the written flag.
- R3: A page write while idle starts that page at once. On the next cycle dma_done=0, nxt_empty stays 1 and cur_pint equals the written flag.
- R4: A page write is ignored when the queued slot is full, or when its count is 0. The queued count and flag are unchanged, and a zero-count write while idle leaves dma_done=1.
- R5: On the clock edge that consumes the last byte of the current page, a full queued slot moves into the current slot together with its flag. dma_done stays 0, nxt_empty becomes 1 and nxt_cnt_rd becomes 0.
- R6: On the clock edge that consumes the last byte while the queued slot is empty, the engine goes idle: dma_done=1 and cur_pint=0.
- R7: With burst_en=0, each consumed byte produces exactly one write, one cycle later. That write has wr_nbytes=1, wr_addr equal to the byte's address, and the byte in wr_data[7:0].
- R8: With burst_en=1, bytes are gathered in groups of GRP (default 4) counted from the page start. Each write has wr_addr equal to the address of its first byte, and the byte at offset k sits in wr_data[8k+7:8k]. The last byte of a page flushes a partial group, with wr_nbytes equal to the bytes left over.
- R9: pg_irq becomes 1 on the edge that consumes the last byte of a page whose flag is 1, provided pint_en=1 at that edge. A page with flag 0, or a page that finishes while pint_en=0, leaves pg_irq unchanged.
- R10: pg_irq stays set while pint_en=1. It goes to 0 on the edge after pint_en is sampled 0.
- R11: irq_out equals pg_irq AND glb_irq_en, registered one cycle later.
- R12: Incoming bytes while idle (dma_done=1) are not consumed and produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nxt_wr | input | 1 | Page write strobe |
| nxt_addr_in | input | AW | Start byte address of the written page |
| nxt_cnt_in | input | CW | Byte count of the written page |
| nxt_pint_in | input | 1 | Page-interrupt flag of the written page |
| pint_en | input | 1 | Local page-interrupt enable; 0 clears pg_irq |
| glb_irq_en | input | 1 | Global interrupt enable gating irq_out |
| burst_en | input | 1 | 1 = grouped writes, 0 = one write per byte |
| byte_vld | input | 1 | An incoming byte is present |
| byte_in | input | 8 | Incoming byte |
| wr_vld | output | 1 | Memory write strobe |
| wr_addr | output | AW | Byte address of the first byte of the write |
| wr_data | output | 8*GRP | Write data, byte k in lane k |
| wr_nbytes | output | $clog2(GRP+1) | Number of valid lanes from lane 0 |
| dma_done | output | 1 | 1 when no page is active |
| nxt_empty | output | 1 | 1 when the queued slot holds no page |
| cur_pint | output | 1 | Flag of the current page |
| nxt_pint | output | 1 | Flag of the queued page |
| nxt_cnt_rd | output | CW | Byte count of the queued page (0 when empty) |
| pg_irq | output | 1 | Sticky page interrupt |
| irq_out | output | 1 | Interrupt pin |

## Verification
The hardest case to reach from the ports is the handoff. A page must finish while another page waits in the queued slot, and the two pages must carry different interrupt flags. The stimulus starts an unflagged page from idle and queues a flagged page behind it before any byte arrives. It then feeds exactly the first page's byte count and samples the status outputs. At that point the engine must still be busy, the queued slot must be empty, the current flag must now be 1, and no interrupt may have been raised yet. Feeding the second page then raises the interrupt. Single-byte and grouped writes are compared against a table of pages with varied lengths and misaligned start addresses. That table includes counts of exactly one group, one group plus one byte, and a single byte.

// File: rtl/sg_pkg.sv
package sg_pkg;
  // Source selected for loading the current page slot
  typedef enum logic [1:0] {
    LD_HOLD       = 2'd0,
    LD_FROM_NEXT  = 2'd1,
    LD_FROM_WRITE = 2'd2
  } cur_load_e;

  localparam int SG_ADDR_W  = 32;
  localparam int SG_COUNT_W = 16;
  localparam int SG_GROUP   = 4;
endpackage

// File: rtl/sg_slot_regs.sv
module sg_slot_regs
  import sg_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_cnt,
  input  logic          wr_flag,
  input  logic          take,
  output logic          cur_active,
  output logic [AW-1:0] cur_addr,
  output logic          cur_flag,
  output logic          last_take,
  output logic          nxt_full,
  output logic [CW-1:0] nxt_cnt,
  output logic          nxt_flag
);
  logic [AW-1:0] nxt_addr_q;
  logic [CW-1:0] cur_rem;
  logic          wr_ok;
  logic          cur_free;
  cur_load_e     ld_sel;

  assign last_take = take && (cur_rem == CW'(1));
  assign wr_ok     = wr_req && !nxt_full && (wr_cnt != '0);
  assign cur_free  = !cur_active || last_take;

  always_comb begin
    ld_sel = LD_HOLD;
    if (cur_free && nxt_full)   ld_sel = LD_FROM_NEXT;
    else if (cur_free && wr_ok) ld_sel = LD_FROM_WRITE;
  end

  // queued slot
  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_full   <= 1'b0;
      nxt_addr_q <= '0;
      nxt_cnt    <= '0;
      nxt_flag   <= 1'b0;
    end else if (ld_sel == LD_FROM_NEXT) begin
      nxt_full   <= 1'b0;
      nxt_cnt    <= '0;
      nxt_flag   <= 1'b0;
    end else if (wr_ok && !cur_free) begin
      nxt_full   <= 1'b1;
      nxt_addr_q <= wr_addr;
      nxt_cnt    <= wr_cnt;
      nxt_flag   <= wr_flag;
    end
  end

  // current slot
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_active <= 1'b0;
      cur_addr   <= '0;
      cur_rem    <= '0;
      cur_flag   <= 1'b0;
    end else begin
      unique case (ld_sel)
        LD_FROM_NEXT: begin
          cur_active <= 1'b1;
          cur_addr   <= nxt_addr_q;
          cur_rem    <= nxt_cnt;
          cur_flag   <= nxt_flag;
        end
        LD_FROM_WRITE: begin
          cur_active <= 1'b1;
          cur_addr   <= wr_addr;
          cur_rem    <= wr_cnt;
          cur_flag   <= wr_flag;
        end
        default: begin
          if (last_take) begin
            cur_active <= 1'b0;
            cur_rem    <= '0;
            cur_flag   <= 1'b0;
            cur_addr   <= cur_addr + AW'(1);
          end else if (take) begin
            cur_rem    <= cur_rem - CW'(1);
            cur_addr   <= cur_addr + AW'(1);
          end
        end
      endcase
    end
  end

  // R5
  promote_chk: assert property (@(posedge clk) disable iff (rst)
    (last_take && nxt_full) |=> (cur_active && !nxt_full));
  // R6
  idle_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (last_take && !nxt_full && !wr_req) |=> !cur_active);
  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (nxt_full && !cur_free) |=> (nxt_full && $stable(nxt_cnt) && $stable(nxt_flag)));
  // R12
  idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (!cur_active && !wr_req) |=> !cur_active);
endmodule

// File: rtl/sg_burst_pack.sv
module sg_burst_pack #(
  parameter int AW  = 32,
  parameter int GRP = 4,
  localparam int DW  = 8 * GRP,
  localparam int NBW = $clog2(GRP + 1),
  localparam int CTW = (GRP > 1) ? $clog2(GRP) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           take,
  input  logic [7:0]     byte_in,
  input  logic [AW-1:0]  byte_addr,
  input  logic           last,
  input  logic           burst_en,
  output logic           wr_vld,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic [NBW-1:0] wr_nbytes
);
  logic [CTW-1:0] acc_n;
  logic [DW-1:0]  acc_data;
  logic [AW-1:0]  acc_addr;
  logic [DW-1:0]  merged;
  logic [AW-1:0]  base_addr;
  logic           flush;

  // place the incoming byte into the lane given by the fill count
  for (genvar g = 0; g < GRP; g++) begin : g_lane
    assign merged[8*g +: 8] = (acc_n == CTW'(g)) ? byte_in : acc_data[8*g +: 8];
  end

  assign flush     = !burst_en || last || (acc_n == CTW'(GRP - 1));
  assign base_addr = (acc_n == '0) ? byte_addr : acc_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_vld    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_nbytes <= '0;
      acc_n     <= '0;
      acc_data  <= '0;
      acc_addr  <= '0;
    end else begin
      wr_vld <= take && flush;
      if (take) begin
        if (flush) begin
          wr_data   <= merged;
          wr_addr   <= base_addr;
          wr_nbytes <= NBW'(acc_n) + NBW'(1);
          acc_n     <= '0;
          acc_data  <= '0;
        end else begin
          acc_n    <= acc_n + CTW'(1);
          acc_data <= merged;
          if (acc_n == '0) acc_addr <= byte_addr;
        end
      end
    end
  end

  // R8
  nbytes_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_vld |-> ((wr_nbytes != '0) && (wr_nbytes <= NBW'(GRP))));
  // R7
  no_take_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> !wr_vld);
endmodule

// File: rtl/sg_irq_unit.sv
module sg_irq_unit (
  input  logic clk,
  input  logic rst,
  input  logic pint_en,
  input  logic glb_en,
  input  logic fin,
  input  logic fin_flag,
  output logic sticky,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sticky <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (!pint_en) sticky <= 1'b0;
      else if (fin && fin_flag) sticky <= 1'b1;
      irq <= sticky && glb_en;
    end
  end

  // R10
  sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !pint_en |=> !sticky);
  // R9
  sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
    (pint_en && fin && fin_flag) |=> sticky);
  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (!sticky && !(fin && fin_flag)) |=> !sticky);
  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> !irq);
endmodule

// File: rtl/sg_page_seq.sv
module sg_page_seq
  import sg_pkg::*;
#(
  parameter int AW  = SG_ADDR_W,
  parameter int CW  = SG_COUNT_W,
  parameter int GRP = SG_GROUP,
  localparam int DW  = 8 * GRP,
  localparam int NBW = $clog2(GRP + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           nxt_wr,
  input  logic [AW-1:0]  nxt_addr_in,
  input  logic [CW-1:0]  nxt_cnt_in,
  input  logic           nxt_pint_in,
  input  logic           pint_en,
  input  logic           glb_irq_en,
  input  logic           burst_en,
  input  logic           byte_vld,
  input  logic [7:0]     byte_in,
  output logic           wr_vld,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic [NBW-1:0] wr_nbytes,
  output logic           dma_done,
  output logic           nxt_empty,
  output logic           cur_pint,
  output logic           nxt_pint,
  output logic [CW-1:0]  nxt_cnt_rd,
  output logic           pg_irq,
  output logic           irq_out
);
  logic          cur_active;
  logic [AW-1:0] cur_addr;
  logic          last_take;
  logic          nxt_full;
  logic          take;

  assign take = byte_vld && cur_active;

  sg_slot_regs #(.AW(AW), .CW(CW)) u_slots (
    .clk        (clk),
    .rst        (rst),
    .wr_req     (nxt_wr),
    .wr_addr    (nxt_addr_in),
    .wr_cnt     (nxt_cnt_in),
    .wr_flag    (nxt_pint_in),
    .take       (take),
    .cur_active (cur_active),
    .cur_addr   (cur_addr),
    .cur_flag   (cur_pint),
    .last_take  (last_take),
    .nxt_full   (nxt_full),
    .nxt_cnt    (nxt_cnt_rd),
    .nxt_flag   (nxt_pint)
  );

  sg_burst_pack #(.AW(AW), .GRP(GRP)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .byte_in   (byte_in),
    .byte_addr (cur_addr),
    .last      (last_take),
    .burst_en  (burst_en),
    .wr_vld    (wr_vld),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_nbytes (wr_nbytes)
  );

  sg_irq_unit u_irq (
    .clk      (clk),
    .rst      (rst),
    .pint_en  (pint_en),
    .glb_en   (glb_irq_en),
    .fin      (last_take),
    .fin_flag (cur_pint),
    .sticky   (pg_irq),
    .irq      (irq_out)
  );

  assign dma_done  = !cur_active;
  assign nxt_empty = !nxt_full;

  // R12
  idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    dma_done |=> !wr_vld);
  // R3
  idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_done && nxt_wr && (nxt_cnt_in != '0)) |=> (!dma_done && nxt_empty));
endmodule

// File: tb/sg_page_seq_tb.sv
module sg_page_seq_tb;
  localparam int AW = 32, CW = 16, GRP = 4;

  logic clk = 0, rst = 1;
  logic nxt_wr = 0, nxt_pint_in = 0, pint_en = 0, glb_irq_en = 0, burst_en = 0, byte_vld = 0;
  logic [AW-1:0] nxt_addr_in = '0;
  logic [CW-1:0] nxt_cnt_in = '0;
  logic [7:0] byte_in = '0;
  logic wr_vld, dma_done, nxt_empty, cur_pint, nxt_pint, pg_irq, irq_out;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;
  logic [2:0] wr_nbytes;
  logic [CW-1:0] nxt_cnt_rd;

  int nchk = 0, nfail = 0, cyc = 0;
  int mon_writes = 0, mon_bytes = 0, mon_left = 0;
  logic mon_chk = 0, mon_burst = 0;
  logic [AW-1:0] mon_addr = '0;

  always #10 clk = ~clk;

  sg_page_seq #(.AW(AW), .CW(CW), .GRP(GRP)) u_dut (
    .clk(clk), .rst(rst), .nxt_wr(nxt_wr), .nxt_addr_in(nxt_addr_in),
    .nxt_cnt_in(nxt_cnt_in), .nxt_pint_in(nxt_pint_in), .pint_en(pint_en),
    .glb_irq_en(glb_irq_en), .burst_en(burst_en), .byte_vld(byte_vld),
    .byte_in(byte_in), .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_nbytes(wr_nbytes), .dma_done(dma_done), .nxt_empty(nxt_empty),
    .cur_pint(cur_pint), .nxt_pint(nxt_pint), .nxt_cnt_rd(nxt_cnt_rd),
    .pg_irq(pg_irq), .irq_out(irq_out)
  );

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_page(input logic [31:0] a, input int n, input logic f);
    @(negedge clk);
    nxt_wr = 1; nxt_addr_in = a; nxt_cnt_in = CW'(n); nxt_pint_in = f;
    @(negedge clk);
    nxt_wr = 0;
  endtask

  task automatic feed(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_vld = 1; byte_in = pat(base + 32'(i));
    end
    @(negedge clk);
    byte_vld = 0;
  endtask

  // write monitor: data lanes always, address and size when enabled (R7, R8)
  always @(negedge clk) begin
    if (!rst && wr_vld) begin
      logic ok;
      int exp_nb;
      ok = 1;
      for (int k = 0; k < int'(wr_nbytes); k++)
        if (wr_data[8*k +: 8] != pat(wr_addr + 32'(k))) ok = 0;
      chk(ok, "R8", "write data lanes", wr_data, 0);
      mon_writes++;
      mon_bytes += int'(wr_nbytes);
      if (mon_chk) begin
        exp_nb = mon_burst ? ((mon_left < GRP) ? mon_left : GRP) : 1;
        chk(wr_addr == mon_addr, mon_burst ? "R8" : "R7", "write address", wr_addr, mon_addr);
        chk(int'(wr_nbytes) == exp_nb, mon_burst ? "R8" : "R7", "write size", wr_nbytes, exp_nb);
        mon_addr = mon_addr + 32'(exp_nb);
        mon_left -= exp_nb;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nfail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  // {burst, flag, pint_en, glb_en, count[15:0], offset[7:0]}
  localparam logic [27:0] VEC [8] = '{
    {4'b0111, 16'd5,  8'd0},
    {4'b1110, 16'd9,  8'd3},
    {4'b1011, 16'd8,  8'd1},
    {4'b1101, 16'd3,  8'd2},
    {4'b0000, 16'd1,  8'd7},
    {4'b1111, 16'd4,  8'd0},
    {4'b1001, 16'd1,  8'd5},
    {4'b1111, 16'd13, 8'd6}
  };

  initial begin
    int w0, b0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(dma_done == 1, "R1", "dma_done", dma_done, 1);
    chk(nxt_empty == 1, "R1", "nxt_empty", nxt_empty, 1);
    chk(nxt_cnt_rd == 0, "R1", "nxt_cnt_rd", nxt_cnt_rd, 0);
    chk(pg_irq == 0 && irq_out == 0, "R1", "irq flags", {pg_irq, irq_out}, 0);
    chk(wr_vld == 0, "R1", "wr_vld", wr_vld, 0);

    for (int v = 0; v < 8; v++) begin
      logic bst, flg, pen, gen;
      int cnt, exp_w;
      logic [31:0] base;
      {bst, flg, pen, gen} = VEC[v][27:24];
      cnt  = int'(VEC[v][23:8]);
      base = 32'h0001_0000 + 32'(v) * 32'h100 + 32'(VEC[v][7:0]);
      @(negedge clk);
      pint_en = 0;
      @(negedge clk);
      pint_en = pen; glb_irq_en = gen; burst_en = bst;
      mon_addr = base; mon_left = cnt; mon_burst = bst; mon_chk = 1;
      w0 = mon_writes; b0 = mon_bytes;
      write_page(base, cnt, flg);
      feed(base, cnt);
      chk(dma_done == 1, "R6", "done after single page", dma_done, 1);
      @(negedge clk);
      exp_w = bst ? (cnt + GRP - 1) / GRP : cnt;
      chk(mon_writes - w0 == exp_w, bst ? "R8" : "R7", "write count", mon_writes - w0, exp_w);
      chk(mon_bytes - b0 == cnt, bst ? "R8" : "R7", "byte total", mon_bytes - b0, cnt);
      chk(pg_irq == (flg & pen), "R9", "sticky after page", pg_irq, flg & pen);
      chk(irq_out == (flg & pen & gen), "R11", "irq pin", irq_out, flg & pen & gen);
      mon_chk = 0;
    end

    // R12 bytes while idle
    @(negedge clk);
    pint_en = 0; glb_irq_en = 0; burst_en = 0;
    w0 = mon_writes;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      byte_vld = 1; byte_in = 8'hA5;
    end
    @(negedge clk);
    byte_vld = 0;
    @(negedge clk);
    chk(mon_writes == w0, "R12", "writes while idle", mon_writes - w0, 0);
    chk(dma_done == 1, "R12", "still idle", dma_done, 1);

    // R4 zero-count write while idle
    write_page(32'h0000_5000, 0, 1);
    chk(dma_done == 1, "R4", "zero count start", dma_done, 1);
    chk(nxt_empty == 1, "R4", "zero count queue", nxt_empty, 1);

    // R3 start from idle
    write_page(32'h0000_2000, 6, 0);
    chk(dma_done == 0, "R3", "dma_done", dma_done, 0);
    chk(nxt_empty == 1, "R3", "nxt_empty", nxt_empty, 1);
    chk(cur_pint == 0, "R3", "cur_pint", cur_pint, 0);

    // R2 queue behind active page
    write_page(32'h0000_3000, 5, 1);
    chk(nxt_empty == 0, "R2", "nxt_empty", nxt_empty, 0);
    chk(nxt_cnt_rd == 5, "R2", "nxt_cnt_rd", nxt_cnt_rd, 5);
    chk(nxt_pint == 1, "R2", "nxt_pint", nxt_pint, 1);

    // R4 write while full
    write_page(32'h0000_4000, 9, 0);
    chk(nxt_cnt_rd == 5, "R4", "count kept when full", nxt_cnt_rd, 5);
    chk(nxt_pint == 1, "R4", "flag kept when full", nxt_pint, 1);

    // R5 handoff
    pint_en = 1;
    feed(32'h0000_2000, 6);
    chk(dma_done == 0, "R5", "stays active", dma_done, 0);
    chk(nxt_empty == 1, "R5", "queue emptied", nxt_empty, 1);
    chk(nxt_cnt_rd == 0, "R5", "queued count cleared", nxt_cnt_rd, 0);
    chk(cur_pint == 1, "R5", "flag moved", cur_pint, 1);
    chk(pg_irq == 0, "R9", "unflagged page no irq", pg_irq, 0);

    // R6 finish with empty queue
    feed(32'h0000_3000, 5);
    chk(dma_done == 1, "R6", "idle after last", dma_done, 1);
    chk(cur_pint == 0, "R6", "cur_pint cleared", cur_pint, 0);
    chk(pg_irq == 1, "R9", "flagged page irq", pg_irq, 1);

    // R11 global gate
    @(negedge clk);
    chk(irq_out == 0, "R11", "gated off", irq_out, 0);
    glb_irq_en = 1;
    @(negedge clk);
    chk(irq_out == 1, "R11", "gated on", irq_out, 1);

    // R10 clear only by enable drop
    repeat (3) @(negedge clk);
    chk(pg_irq == 1, "R10", "sticky holds", pg_irq, 1);
    pint_en = 0;
    @(negedge clk);
    chk(pg_irq == 0, "R10", "cleared by enable", pg_irq, 0);
    pint_en = 1;
    @(negedge clk);
    chk(irq_out == 0, "R11", "pin follows clear", irq_out, 0);
    chk(pg_irq == 0, "R10", "stays clear", pg_irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule